// File: doc/BRIEF.md
# DDR3 command timing enforcer

The block sits between a DDR3 command scheduler and the command bus of the PHY. It serves one rank of eight banks. Each controller clock it decides whether the command that the scheduler presents is legal. The command may be an activate, a column read, a column write, a precharge, a refresh or a mode-register write. A legal command is granted and passed on to the PHY in the same cycle. Any other command is held off until every spacing rule that applies to it has run out. The block also tracks which banks are open. A read or write aimed at a closed bank is consumed and flagged as an error, and the PHY never sees it.

The spacing limits given in nanoseconds are turned into clock counts at elaboration from a clock-frequency parameter, and each count is rounded up. At the default 400 MHz this gives activate-to-column 5, activate-to-precharge 15, activate-to-activate 20, precharge-to-activate 5 and refresh recovery 140 clocks. A free-running timer raises a refresh request once per programmed refresh interval, and the request stays up until a refresh is granted.

Commands use a valid/ready handshake. The scheduler holds `cmd_valid` and its command fields stable until `cmd_ready` is seen high at a clock edge. Command codes: 0 activate, 1 read, 2 write, 3 precharge, 4 refresh, 5 mode-register write. Codes 6 and 7 are unused.

Top module: `ddr3_cmd_gate`

## Requirements
- R1: `cmd_ready` is high only in a cycle where the presented command meets every rule below, or is an error per R12. `phy_vld` is high exactly when a legal command is accepted, and in that cycle `phy_type`, `phy_bank` and `phy_row` copy the command. After reset all banks are closed, no refresh is requested and an activate is accepted at once.
- R2: Two column commands (read or write, to any banks) are at least 4 clocks apart.
- R3: A read or write to a bank comes at least ceil(12.5 ns × f) clocks after that bank's activate (5 at 400 MHz).
- R4: A precharge to a bank comes at least ceil(37.5 ns × f) clocks after that bank's activate (15), and a second activate to the same bank comes at least ceil(50 ns × f) clocks after the first (20).
- R5: An activate to a bank comes at least ceil(12.5 ns × f) clocks after that bank's precharge (5).
- R6: A precharge to a bank comes at least 4 clocks after a read to that bank.
- R7: After a write, a read to any bank waits write latency 5 plus 4 burst clocks plus 4 clocks (13 in total). A precharge to the written bank waits 5 plus 4 plus a write recovery of 6 (15 in total).
- R8: After a refresh, no activate and no refresh is accepted for ceil(350 ns × f) clocks (140).
- R9: A refresh is accepted only when every bank is closed and every bank's precharge-to-activate time has run out.
- R10: Mode-register writes are at least 4 clocks apart. Any other command waits 12 clocks after one. A mode-register write needs the same idle condition as a refresh.
- R11: `ref_req` rises ceil(tREFI × f) clocks after reset is released (320 for 800 ns at 400 MHz) and then once every such interval. It stays high until a refresh is granted, and it drops in the cycle after the grant.
- R12: A read or write to a closed bank, or an unused code (6, 7), is accepted with `cmd_err` high and `cmd_ready` high. `phy_vld` stays low and no bank or timing state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Scheduler presents a command |
| cmd_type | input | 3 | Command code (0 ACT, 1 RD, 2 WR, 3 PRE, 4 REF, 5 MRS) |
| cmd_bank | input | 3 | Target bank |
| cmd_row | input | ROW_W | Row or mode-register payload |
| cmd_ready | output | 1 | Command accepted this cycle |
| cmd_err | output | 1 | Accepted command is rejected as illegal |
| phy_vld | output | 1 | Command issued to the PHY this cycle |
| phy_type | output | 3 | Issued command code |
| phy_bank | output | 3 | Issued bank |
| phy_row | output | ROW_W | Issued row or payload |
| ref_req | output | 1 | Refresh is due |

## Verification
Some rules are checked by the assertions on every clock. These are the handshake relation between grant, error and PHY issue, the rank-wide column spacing, the mode-register spacing, the refresh recovery window, and the rule that the refresh request is held until a refresh is granted. The per-bank windows depend on which bank was touched and by which earlier command. These are activate-to-column, activate-to-precharge, activate-to-activate, precharge-to-activate, read-to-precharge and the write turnarounds, and only the directed scenarios show them: each scenario measures the exact grant cycle against the count it expects. The same holds for the exact refresh period, the idle condition for refresh, and the fact that a rejected command leaves no trace.

// File: rtl/ddr3_cmd_gate.sv
module ddr3_cmd_gate #(
  parameter int CLK_MHZ  = 400,
  parameter int TREFI_NS = 7800,
  parameter int ROW_W    = 16,
  parameter int BANK_W   = 3,
  parameter int TCCD     = 4,
  parameter int TRTP     = 4,
  parameter int TWTR     = 4,
  parameter int TWR      = 6,
  parameter int CWL      = 5,
  parameter int BL       = 8,
  parameter int TMRD     = 4,
  parameter int TMOD     = 12,
  parameter int TRCD_PS  = 12500,
  parameter int TRAS_PS  = 37500,
  parameter int TRC_PS   = 50000,
  parameter int TRP_PS   = 12500,
  parameter int TRFC_PS  = 350000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_type,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_row,
  output logic              cmd_ready,
  output logic              cmd_err,
  output logic              phy_vld,
  output logic [2:0]        phy_type,
  output logic [BANK_W-1:0] phy_bank,
  output logic [ROW_W-1:0]  phy_row,
  output logic              ref_req
);

  function automatic int ps2ck(input int ps);
    return (ps * CLK_MHZ + 999999) / 1000000;
  endfunction

  localparam int NB      = 1 << BANK_W;
  localparam int TRCD_C  = ps2ck(TRCD_PS);
  localparam int TRAS_C  = ps2ck(TRAS_PS);
  localparam int TRC_C   = ps2ck(TRC_PS);
  localparam int TRP_C   = ps2ck(TRP_PS);
  localparam int TRFC_C  = ps2ck(TRFC_PS);
  localparam int TREFI_C = ((TREFI_NS * CLK_MHZ + 999) / 1000 < 1) ? 1 : (TREFI_NS * CLK_MHZ + 999) / 1000;
  localparam int WEND    = CWL + BL / 2;
  localparam int W2R     = WEND + TWTR;
  localparam int W2P     = WEND + TWR;
  localparam int CMAX    = TRFC_C + TRC_C + W2P + TMOD;
  localparam int CW      = $clog2(CMAX + 1);
  localparam int TW      = $clog2(TREFI_C + 1);

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c, input logic ld, input int n);
    int d;
    d = (c == '0) ? 0 : int'(c) - 1;
    if (ld && (n - 1) > d) d = n - 1;
    return CW'(d);
  endfunction

  logic is_act, is_rd, is_wr, is_pre, is_ref, is_mrs;
  assign is_act = cmd_type == 3'd0;
  assign is_rd  = cmd_type == 3'd1;
  assign is_wr  = cmd_type == 3'd2;
  assign is_pre = cmd_type == 3'd3;
  assign is_ref = cmd_type == 3'd4;
  assign is_mrs = cmd_type == 3'd5;

  logic [NB-1:0] open_v, act_z, rw_z, pre_z;
  logic [CW-1:0] col_c, wtr_c, rfc_c, mrd_c, mod_c;
  logic          bad, ok, go, idle;

  assign idle = (open_v == '0) && (&act_z);
  assign bad  = ((is_rd | is_wr) & ~open_v[cmd_bank]) | (cmd_type > 3'd5);

  always_comb begin
    case (cmd_type)
      3'd0:    ok = ~open_v[cmd_bank] & act_z[cmd_bank] & (rfc_c == '0) & (mod_c == '0);
      3'd1:    ok = rw_z[cmd_bank] & (col_c == '0) & (wtr_c == '0) & (mod_c == '0);
      3'd2:    ok = rw_z[cmd_bank] & (col_c == '0) & (mod_c == '0);
      3'd3:    ok = pre_z[cmd_bank] & (mod_c == '0);
      3'd4:    ok = idle & (rfc_c == '0) & (mod_c == '0);
      3'd5:    ok = idle & (rfc_c == '0) & (mrd_c == '0);
      default: ok = 1'b0;
    endcase
  end

  assign cmd_ready = bad | ok;
  assign cmd_err   = cmd_valid & bad;
  assign go        = cmd_valid & ok & ~bad;

  assign phy_vld  = go;
  assign phy_type = cmd_type;
  assign phy_bank = cmd_bank;
  assign phy_row  = cmd_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_c <= '0;
      wtr_c <= '0;
      rfc_c <= '0;
      mrd_c <= '0;
      mod_c <= '0;
    end else begin
      col_c <= step(col_c, go & (is_rd | is_wr), TCCD);
      wtr_c <= step(wtr_c, go & is_wr, W2R);
      rfc_c <= step(rfc_c, go & is_ref, TRFC_C);
      mrd_c <= step(mrd_c, go & is_mrs, TMRD);
      mod_c <= step(mod_c, go & is_mrs, TMOD);
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [CW-1:0] a_c, r_c, p_c;
    logic          op, hit;
    assign hit = go && (cmd_bank == BANK_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        a_c <= '0;
        r_c <= '0;
        p_c <= '0;
        op  <= 1'b0;
      end else begin
        a_c <= step(a_c, hit & (is_act | is_pre), is_act ? TRC_C : TRP_C);
        r_c <= step(r_c, hit & is_act, TRCD_C);
        p_c <= step(p_c, hit & (is_act | is_rd | is_wr),
                    is_act ? TRAS_C : (is_rd ? TRTP : W2P));
        if (hit & is_act)      op <= 1'b1;
        else if (hit & is_pre) op <= 1'b0;
      end
    end
    assign open_v[b] = op;
    assign act_z[b]  = a_c == '0;
    assign rw_z[b]   = r_c == '0;
    assign pre_z[b]  = p_c == '0;
  end

  logic [TW-1:0] tmr;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr     <= TW'(TREFI_C - 1);
      ref_req <= 1'b0;
    end else begin
      tmr <= (tmr == '0) ? TW'(TREFI_C - 1) : tmr - 1'b1;
      if (tmr == '0)        ref_req <= 1'b1;
      else if (go & is_ref) ref_req <= 1'b0;
    end
  end

endmodule

// File: rtl/ddr3_cmd_gate_chk.sv
module ddr3_cmd_gate_chk #(
  parameter int CLK_MHZ = 400,
  parameter int TRFC_PS = 350000,
  parameter int TCCD    = 4,
  parameter int TMRD    = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       cmd_err,
  input logic       phy_vld,
  input logic [2:0] phy_type,
  input logic       ref_req
);
  localparam int TRFC_C = (TRFC_PS * CLK_MHZ + 999999) / 1000000;

  logic [15:0] col_since, mrs_since, ref_since;
  logic        col_go, mrs_go, ref_go, act_go;
  assign col_go = phy_vld && (phy_type == 3'd1 || phy_type == 3'd2);
  assign mrs_go = phy_vld && phy_type == 3'd5;
  assign ref_go = phy_vld && phy_type == 3'd4;
  assign act_go = phy_vld && phy_type == 3'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_since <= '1;
      mrs_since <= '1;
      ref_since <= '1;
    end else begin
      col_since <= col_go ? 16'd1 : (col_since == '1 ? col_since : col_since + 1'b1);
      mrs_since <= mrs_go ? 16'd1 : (mrs_since == '1 ? mrs_since : mrs_since + 1'b1);
      ref_since <= ref_go ? 16'd1 : (ref_since == '1 ? ref_since : ref_since + 1'b1);
    end
  end

  // R1
  hs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_vld |-> (cmd_valid && cmd_ready && !cmd_err));
  // R12
  err_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (cmd_ready && !phy_vld));
  // R2
  col_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_go |-> (col_since >= 16'(TCCD)));
  // R10
  mrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_go |-> (mrs_since >= 16'(TMRD)));
  // R8
  rfc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_go || act_go) |-> (ref_since >= 16'(TRFC_C)));
  // R11
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_go) |=> ref_req);
endmodule

bind ddr3_cmd_gate ddr3_cmd_gate_chk #(
  .CLK_MHZ(CLK_MHZ), .TRFC_PS(TRFC_PS), .TCCD(TCCD), .TMRD(TMRD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_err(cmd_err), .phy_vld(phy_vld), .phy_type(phy_type), .ref_req(ref_req)
);

// File: tb/sim_ddr3_cmd_gate.sv
`timescale 1ns/1ps
module sim_ddr3_cmd_gate;
  localparam int TREFI_C = (800 * 400 + 999) / 1000;

  logic        clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [2:0]  cmd_type = 3'd0, cmd_bank = 3'd0;
  logic [15:0] cmd_row = '0;
  logic        cmd_ready, cmd_err, phy_vld, ref_req;
  logic [2:0]  phy_type, phy_bank;
  logic [15:0] phy_row;
  int total = 0, bad = 0, cyc = 0;

  ddr3_cmd_gate #(.TREFI_NS(800)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_ready(cmd_ready), .cmd_err(cmd_err),
    .phy_vld(phy_vld), .phy_type(phy_type), .phy_bank(phy_bank), .phy_row(phy_row),
    .ref_req(ref_req));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [2:0] t, input logic [2:0] b, input int r, output int at);
    int n = 0;
    cmd_type = t; cmd_bank = b; cmd_row = r[15:0]; cmd_valid = 1'b1;
    #1;
    while (!cmd_ready && n < 600) begin
      @(negedge clk); #1; n++;
    end
    at = cmd_ready ? cyc : -1;
    chk("R1 issue", int'(phy_vld && phy_type == t && phy_bank == b && phy_row == r[15:0]), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic hold_off(input logic [2:0] t, input logic [2:0] b, input int n, input string req);
    int seen = 0;
    cmd_type = t; cmd_bank = b; cmd_valid = 1'b1;
    for (int i = 0; i < n; i++) begin
      #1; seen |= int'(cmd_ready);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(req, seen, 0);
  endtask

  task automatic t_reset();
    int a;
    do_reset();
    #1;
    chk("R1 reset phy_vld", int'(phy_vld), 0);
    chk("R11 reset ref_req", int'(ref_req), 0);
    chk("R12 reset err", int'(cmd_err), 0);
    send(3'd0, 3'd7, 16'h1234, a);
    chk("R1 act after reset", a, cyc - 1);
  endtask

  task automatic t_read_path();
    int a, r1, r2, r3, p, a2;
    do_reset();
    send(3'd0, 3'd1, 16'h0011, a);
    send(3'd1, 3'd1, 16'h0020, r1);
    chk("R3 act->rd", r1 - a, 5);
    send(3'd1, 3'd1, 16'h0028, r2);
    chk("R2 rd->rd", r2 - r1, 4);
    repeat (12) @(negedge clk);
    send(3'd1, 3'd1, 16'h0030, r3);
    send(3'd3, 3'd1, 16'h0000, p);
    chk("R6 rd->pre", p - r3, 4);
    send(3'd0, 3'd1, 16'h0012, a2);
    chk("R5 pre->act", a2 - p, 5);
  endtask

  task automatic t_ras_rc();
    int a, p, a2;
    do_reset();
    send(3'd0, 3'd2, 16'h0200, a);
    send(3'd3, 3'd2, 16'h0000, p);
    chk("R4 act->pre", p - a, 15);
    send(3'd0, 3'd2, 16'h0201, a2);
    chk("R4 act->act", a2 - a, 20);
  endtask

  task automatic t_write_path();
    int a, a4, w, r, p;
    do_reset();
    send(3'd0, 3'd3, 16'h0300, a);
    send(3'd0, 3'd4, 16'h0400, a4);
    chk("R1 other-bank act", a4 - a, 1);
    send(3'd2, 3'd3, 16'h0008, w);
    chk("R3 act->wr", w - a, 5);
    send(3'd1, 3'd4, 16'h0010, r);
    chk("R7 wr->rd", r - w, 13);
    send(3'd3, 3'd3, 16'h0000, p);
    chk("R7 wr->pre", p - w, 15);
  endtask

  task automatic t_errors();
    int a, r;
    do_reset();
    cmd_bank = 3'd5; cmd_type = 3'd1; cmd_valid = 1'b1;
    #1;
    chk("R12 rd closed ready", int'(cmd_ready), 1);
    chk("R12 rd closed err", int'(cmd_err), 1);
    chk("R12 rd closed phy", int'(phy_vld), 0);
    @(negedge clk); cmd_type = 3'd2; #1;
    chk("R12 wr closed err", int'(cmd_err && !phy_vld), 1);
    @(negedge clk); cmd_type = 3'd7; #1;
    chk("R12 code7 err", int'(cmd_err && cmd_ready && !phy_vld), 1);
    @(negedge clk); cmd_valid = 1'b0;
    send(3'd0, 3'd5, 16'h0500, a);
    chk("R12 state kept act", a, cyc - 1);
    send(3'd1, 3'd5, 16'h0000, r);
    chk("R12 no col window", r - a, 5);
    #1;
    chk("R12 open bank no err", int'(cmd_err), 0);
  endtask

  task automatic t_refresh();
    int a, p, g, g2, a2;
    do_reset();
    send(3'd0, 3'd0, 16'h0001, a);
    hold_off(3'd4, 3'd0, 10, "R9 ref while open");
    send(3'd3, 3'd0, 16'h0000, p);
    send(3'd4, 3'd0, 16'h0000, g);
    chk("R9 pre->ref", g - p, 5);
    send(3'd4, 3'd0, 16'h0000, g2);
    chk("R8 ref->ref", g2 - g, 140);
    send(3'd0, 3'd0, 16'h0002, a2);
    chk("R8 ref->act", a2 - g2, 140);
  endtask

  task automatic t_mrs();
    int a, p, m1, m2, x;
    do_reset();
    send(3'd0, 3'd6, 16'h0600, a);
    hold_off(3'd5, 3'd0, 5, "R10 mrs while open");
    send(3'd3, 3'd6, 16'h0000, p);
    send(3'd5, 3'd0, 16'h0A5A, m1);
    chk("R10 idle->mrs", m1 - p, 5);
    send(3'd5, 3'd1, 16'h0003, m2);
    chk("R10 mrs->mrs", m2 - m1, 4);
    send(3'd0, 3'd6, 16'h0601, x);
    chk("R10 mrs->act", x - m2, 12);
  endtask

  task automatic t_timer();
    int c0, n, g;
    do_reset();
    c0 = cyc;
    n = 0;
    while (!ref_req && n < 1000) begin @(negedge clk); n++; end
    chk("R11 first req", cyc - c0, TREFI_C);
    repeat (10) @(negedge clk);
    chk("R11 req held", int'(ref_req), 1);
    send(3'd4, 3'd0, 16'h0000, g);
    chk("R11 req cleared", int'(ref_req), 0);
    n = 0;
    while (!ref_req && n < 1000) begin @(negedge clk); n++; end
    chk("R11 second req", cyc - c0, 2 * TREFI_C);
  endtask

  initial begin
    t_reset();
    t_read_path();
    t_ras_rc();
    t_write_path();
    t_errors();
    t_refresh();
    t_mrs();
    t_timer();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(10 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule